// File: doc/BRIEF.md
# DRAM DLL Lock Command Guard

This block sits between the command scheduler of a DDR SDRAM controller and the memory command bus. It issues extended mode register writes, which carry the DLL switch, the output drive selection and the optional bus-isolation output enable. It follows whether the DLL is running and holds back scheduler commands until the DLL has had time to settle.

It keeps two readiness timers: one for reads and one for all other commands. Their reload values depend on what turned the DLL on. A register write that enables the DLL lets non-read commands through after 2 clocks and reads after 200. Leaving self refresh turns the DLL back on by itself. After that, non-reads wait 10 clocks and reads wait 200. Entering self refresh turns the DLL off.

Scheduler requests use a valid/ready handshake. A blocked request is stalled and never dropped. The block also keeps a shadow copy of the last value written to the extended register.

Top module: `dll_cmd_guard`

## Requirements
- R1: During and after reset, the bus carries NOP (`bus_cmd` 0) and both grants are low. Scheduler requests are stalled until a register write with A0=0 has been issued. A register write can be accepted straight away when all banks are idle.
- R2: An accepted register write shows on the bus in the next cycle with these values:
  - `bus_cmd` is 1 (mode register set).
  - `bus_ba` is 2'b01 (bank bit 0 high, bank bit 1 low).
  - `bus_addr[2:0]` carries the written bits: bit 0 is DLL off, bit 1 is drive select, bit 2 is isolation output enable. The upper address bits are zero.
  - `emr_shadow` takes the written bits in the same cycle.
- R3: A register write is accepted only while `banks_idle` is high. While the banks are busy, the request is held and the bus stays NOP. It is issued once the banks are idle.
- R4: After a register write with A0=0, a non-read command (`bus_cmd` 3) first reaches the bus 2 cycles after the write. It carries the request's bank and address bits.
- R5: After a register write with A0=0, a read (`bus_cmd` 2) first reaches the bus 200 cycles after the write.
- R6: After a register write with A0=1 (DLL off), reads stay blocked and `rd_grant` stays low. Non-reads still pass after 2 cycles.
- R7: An `sr_enter` pulse puts self-refresh entry (`bus_cmd` 4) on the bus. It turns the DLL off. Until self refresh ends, it holds both grants and `emr_ready` low.
- R8: An `sr_exit` pulse puts self-refresh exit (`bus_cmd` 5) on the bus and turns the DLL on. The first non-read then appears 10 cycles later, and the first read 200 cycles later.
- R9: A stalled request keeps `req_ready` low and is not lost. It is issued once its class is granted.
- R10: Self-refresh events take priority over a register write, and a register write takes priority over a scheduler request. The loser sees its ready signal low in that cycle.
- R11: `emr_shadow` keeps its value across self refresh until the register is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Scheduler command request |
| req_is_read | input | 1 | Request is a read (1) or a non-read (0) |
| req_ba | input | 2 | Request bank address |
| req_addr | input | ADDR_W | Request address |
| req_ready | output | 1 | Request accepted this cycle |
| emr_valid | input | 1 | Extended register write request |
| emr_bits | input | 3 | Value to write: DLL off, drive select, isolation enable |
| emr_ready | output | 1 | Register write accepted this cycle |
| banks_idle | input | 1 | All banks idle |
| sr_enter | input | 1 | Enter self refresh (pulse) |
| sr_exit | input | 1 | Exit self refresh (pulse) |
| bus_cmd | output | 3 | Command code: 0 NOP, 1 MRS, 2 read, 3 non-read, 4 SR entry, 5 SR exit |
| bus_ba | output | 2 | Bank address lines |
| bus_addr | output | ADDR_W | Address lines |
| rd_grant | output | 1 | Read class allowed |
| nr_grant | output | 1 | Non-read class allowed |
| emr_shadow | output | 3 | Last written extended register value |

## Verification
A register write and a granted scheduler request can arrive in the same cycle. A self-refresh exit and a register write can also fall in the same cycle. The bench sets up both collisions:
- It raises a register write together with a pending non-read at a moment when non-reads are granted. It checks that `req_ready` is low, that the mode register set reaches the bus first, and that the stalled non-read follows exactly 2 cycles later.
- It raises `sr_exit` together with a register write. It checks that `emr_ready` is low and that the exit command is the one that appears on the bus.

// File: rtl/dll_cmd_guard.sv
module dll_cmd_guard #(
  parameter int ADDR_W    = 13,
  parameter int T_RD_LOCK = 200,
  parameter int T_NR_MRS  = 2,
  parameter int T_NR_SRX  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_is_read,
  input  logic [1:0]        req_ba,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  input  logic              emr_valid,
  input  logic [2:0]        emr_bits,
  output logic              emr_ready,
  input  logic              banks_idle,
  input  logic              sr_enter,
  input  logic              sr_exit,
  output logic [2:0]        bus_cmd,
  output logic [1:0]        bus_ba,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              rd_grant,
  output logic              nr_grant,
  output logic [2:0]        emr_shadow
);
  localparam int CNT_MAX = (T_RD_LOCK > T_NR_SRX) ?
                           ((T_RD_LOCK > T_NR_MRS) ? T_RD_LOCK : T_NR_MRS) :
                           ((T_NR_SRX > T_NR_MRS) ? T_NR_SRX : T_NR_MRS);
  localparam int CW = $clog2(CNT_MAX + 1);
  localparam logic [2:0] C_NOP = 3'd0, C_MRS = 3'd1, C_RD = 3'd2,
                         C_NRD = 3'd3, C_SRE = 3'd4, C_SRX = 3'd5;

  logic          configured, dll_on, in_sr;
  logic [CW-1:0] rd_cnt, nr_cnt;

  wire do_sre   = sr_enter & ~in_sr;
  wire do_srx   = sr_exit & in_sr;
  wire sr_evt   = do_sre | do_srx;

  assign emr_ready = banks_idle & ~in_sr & (nr_cnt == '0) & ~sr_evt;
  wire   emr_fire  = emr_valid & emr_ready;

  assign rd_grant  = configured & dll_on & ~in_sr & (rd_cnt == '0);
  assign nr_grant  = configured & ~in_sr & (nr_cnt == '0);
  assign req_ready = (req_is_read ? rd_grant : nr_grant) & ~emr_fire & ~sr_evt;
  wire   req_fire  = req_valid & req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      configured <= 1'b0;
      dll_on     <= 1'b0;
      in_sr      <= 1'b0;
      rd_cnt     <= '0;
      nr_cnt     <= '0;
      emr_shadow <= '0;
      bus_cmd    <= C_NOP;
      bus_ba     <= '0;
      bus_addr   <= '0;
    end else begin
      if (rd_cnt != '0) rd_cnt <= rd_cnt - 1'b1;
      if (nr_cnt != '0) nr_cnt <= nr_cnt - 1'b1;
      bus_cmd  <= C_NOP;
      bus_ba   <= '0;
      bus_addr <= '0;
      if (do_sre) begin
        bus_cmd <= C_SRE;
        in_sr   <= 1'b1;
        dll_on  <= 1'b0;
      end else if (do_srx) begin
        bus_cmd <= C_SRX;
        in_sr   <= 1'b0;
        dll_on  <= 1'b1;
        rd_cnt  <= CW'(T_RD_LOCK - 1);
        nr_cnt  <= CW'(T_NR_SRX - 1);
      end else if (emr_fire) begin
        bus_cmd    <= C_MRS;
        bus_ba     <= 2'b01;
        bus_addr   <= ADDR_W'(emr_bits);
        emr_shadow <= emr_bits;
        nr_cnt     <= CW'(T_NR_MRS - 1);
        dll_on     <= ~emr_bits[0];
        if (!emr_bits[0]) begin
          configured <= 1'b1;
          rd_cnt     <= CW'(T_RD_LOCK - 1);
        end
      end else if (req_fire) begin
        bus_cmd  <= req_is_read ? C_RD : C_NRD;
        bus_ba   <= req_ba;
        bus_addr <= req_addr;
      end
    end
  end
endmodule

// File: rtl/dll_cmd_guard_chk.sv
module dll_cmd_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_is_read,
  input logic       req_ready,
  input logic       emr_valid,
  input logic       emr_ready,
  input logic       banks_idle,
  input logic [2:0] bus_cmd,
  input logic [1:0] bus_ba,
  input logic       rd_grant,
  input logic       nr_grant
);
  AST_EMR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (emr_valid && emr_ready) |-> banks_idle); // R3
  AST_EMR_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (emr_valid && emr_ready) |=> (bus_cmd == 3'd1 && bus_ba == 2'b01)); // R2
  AST_MRS_NR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd == 3'd1) |-> !nr_grant); // R4
  AST_READ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_is_read && req_ready) |-> rd_grant); // R5
  AST_SR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd == 3'd4) |-> (!rd_grant && !nr_grant && !emr_ready)); // R7
  AST_SRX_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd == 3'd5) |-> !rd_grant); // R8
  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    !(emr_valid && emr_ready && req_valid && req_ready)); // R10
endmodule

bind dll_cmd_guard dll_cmd_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_read(req_is_read),
  .req_ready(req_ready), .emr_valid(emr_valid), .emr_ready(emr_ready),
  .banks_idle(banks_idle), .bus_cmd(bus_cmd), .bus_ba(bus_ba),
  .rd_grant(rd_grant), .nr_grant(nr_grant)
);

// File: tb/tb_dll_cmd_guard.sv
module tb_dll_cmd_guard;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 13;
  localparam int NV = 6;
  localparam logic [3:0] VEC [NV] = '{4'b000_1, 4'b010_1, 4'b001_0,
                                      4'b111_0, 4'b100_1, 4'b110_1};

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_is_read = 0, emr_valid = 0, banks_idle = 1;
  logic sr_enter = 0, sr_exit = 0;
  logic [1:0] req_ba = 2'b10;
  logic [AW-1:0] req_addr = 13'h0a5;
  logic [2:0] emr_bits = 3'b000;
  logic req_ready, emr_ready, rd_grant, nr_grant;
  logic [2:0] bus_cmd, emr_shadow;
  logic [1:0] bus_ba;
  logic [AW-1:0] bus_addr;
  int errors = 0, checks = 0, cyc = 0, got;

  always #(CLK_PERIOD/2) clk = ~clk;

  dll_cmd_guard dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_read(req_is_read),
    .req_ba(req_ba), .req_addr(req_addr), .req_ready(req_ready),
    .emr_valid(emr_valid), .emr_bits(emr_bits), .emr_ready(emr_ready),
    .banks_idle(banks_idle), .sr_enter(sr_enter), .sr_exit(sr_exit),
    .bus_cmd(bus_cmd), .bus_ba(bus_ba), .bus_addr(bus_addr),
    .rd_grant(rd_grant), .nr_grant(nr_grant), .emr_shadow(emr_shadow));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_emr(input logic [2:0] bits);
    @(negedge clk);
    emr_valid = 1; emr_bits = bits;
    #1;
    while (!emr_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    emr_valid = 0;
    cyc = 0;
  endtask

  task automatic wait_cmd(input logic rd, input int limit, output int found);
    req_valid = 1; req_is_read = rd;
    found = -1;
    for (int i = 0; i < limit && found < 0; i++) begin
      @(negedge clk);
      cyc++;
      if (bus_cmd == (rd ? 3'd2 : 3'd3)) found = cyc;
    end
    req_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(bus_cmd == 0, "R1 reset bus", bus_cmd, 0);
    chk(!rd_grant && !nr_grant, "R1 reset grants", {rd_grant, nr_grant}, 0);
    chk(emr_ready == 1, "R1 reset emr_ready", emr_ready, 1);
    rst_n = 1;
    req_valid = 1; req_is_read = 0;
    #1 chk(req_ready == 0, "R9 stall before config", req_ready, 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(bus_cmd == 0, "R1 no cmd before config", bus_cmd, 0);
    end
    req_valid = 0;

    banks_idle = 0; emr_valid = 1; emr_bits = 3'b000;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      chk(emr_ready == 0 && bus_cmd == 0, "R3 held while busy", bus_cmd, 0);
    end
    banks_idle = 1;
    @(negedge clk);
    emr_valid = 0;
    chk(bus_cmd == 1, "R3 issued when idle", bus_cmd, 1);

    for (int v = 0; v < NV; v++) begin
      do_emr(VEC[v][3:1]);
      chk(bus_cmd == 1 && bus_ba == 2'b01, "R2 MRS encoding", {bus_cmd, bus_ba}, 5'b00101);
      chk(bus_addr == AW'(VEC[v][3:1]), "R2 address bits", bus_addr, VEC[v][3:1]);
      chk(emr_shadow == VEC[v][3:1], "R2 shadow", emr_shadow, VEC[v][3:1]);
      req_addr = AW'(13'h100 + v);
      wait_cmd(0, 20, got);
      chk(got == 2, "R4 non-read gap", got, 2);
      chk(bus_addr == req_addr && bus_ba == req_ba, "R4 address pass", bus_addr, req_addr);
      if (VEC[v][0]) begin
        wait_cmd(1, 300, got);
        chk(got == 200, "R5 read gap", got, 200);
      end else begin
        wait_cmd(1, 250, got);
        chk(got == -1, "R6 read blocked", got, -1);
        chk(rd_grant == 0, "R6 rd_grant low", rd_grant, 0);
      end
    end

    @(negedge clk);
    emr_valid = 1; emr_bits = 3'b110; req_valid = 1; req_is_read = 0;
    #1 chk(req_ready == 0 && emr_ready == 1, "R10 write beats request", req_ready, 0);
    @(negedge clk);
    emr_valid = 0; cyc = 0;
    chk(bus_cmd == 1, "R10 MRS first", bus_cmd, 1);
    wait_cmd(0, 20, got);
    chk(got == 2, "R9 stalled request issued", got, 2);

    @(negedge clk);
    sr_enter = 1;
    @(negedge clk);
    sr_enter = 0;
    chk(bus_cmd == 4, "R7 SR entry", bus_cmd, 4);
    chk(!rd_grant && !nr_grant, "R7 grants low", {rd_grant, nr_grant}, 0);
    emr_valid = 1; emr_bits = 3'b000;
    #1 chk(emr_ready == 0, "R7 emr blocked", emr_ready, 0);
    emr_valid = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(bus_cmd == 0, "R7 quiet in SR", bus_cmd, 0);
    end
    sr_exit = 1; emr_valid = 1;
    #1 chk(emr_ready == 0, "R10 SR exit beats write", emr_ready, 0);
    @(negedge clk);
    sr_exit = 0; emr_valid = 0; cyc = 0;
    chk(bus_cmd == 5, "R8 SR exit cmd", bus_cmd, 5);
    chk(emr_shadow == 3'b110, "R11 shadow kept", emr_shadow, 6);
    wait_cmd(0, 30, got);
    chk(got == 10, "R8 non-read gap", got, 10);
    wait_cmd(1, 300, got);
    chk(got == 200, "R8 read gap", got, 200);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule